// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit up-counter whose increment source depends on a mode select. In event mode it counts qualified transitions on an external pin. In gated mode it counts ticks of an internal time base only while that pin sits at its active level. The time base is formed by dividing a fast source enable by 2^8. With a 4 MHz source, one gated tick is 64 µs and a full 256-count wrap takes 16.384 ms.

The external pin first passes through a two-stage synchroniser. A polarity select then picks one of two behaviours. In event mode it chooses rising or falling edges. In gated mode it chooses an active-high or active-low gate. The edge detector resolves pulse trains as fast as one event every two bus clocks.

Software can load the counter and read it in any cycle, even while counting is under way. A wrap from 0xFF to 0x00 sets a sticky overflow flag. Writing a one clears that flag, and the flag can raise an interrupt request when its enable is set. A global enable freezes all counting.

Top module: `pulse_acc`

## Requirements
- R1: After reset the counter reads 0x00 and both the overflow flag and the interrupt request are 0.
- R2: With mode_gated=0 and pol_sel=0, each rising edge of ext_pin adds one to the counter and falling edges add nothing. The new value is visible after the third rising clock edge that follows the pin change.
- R3: With mode_gated=0 and pol_sel=1, each falling edge of ext_pin adds one to the counter and rising edges add nothing.
- R4: In event mode the block counts every edge of a pin that toggles on every clock cycle, which is one event per two bus clocks.
- R5: With mode_gated=1 and src_en held at 1, the counter adds one every 256 clocks while the gate is active. The gate is active when the synchronised pin is 1 with pol_sel=0, or 0 with pol_sel=1.
- R6: With mode_gated=1, the counter holds its value while the gate is inactive.
- R7: When cnt_we is 1, the counter takes cnt_wdata at that clock edge, even if an increment falls in the same cycle.
- R8: An increment from 0xFF to 0x00 sets ovf_flag, and the flag stays set until a cycle with ovf_w1c=1 clears it. If a wrap and ovf_w1c fall in the same cycle, the flag ends up set.
- R9: ovf_irq is 1 exactly when ovf_flag is 1 and ovf_ie is 1.
- R10: While acc_en is 0, the counter changes only through bus writes, and ovf_flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Global counting enable |
| mode_gated | input | 1 | 0 = event counting, 1 = gated accumulation |
| pol_sel | input | 1 | Edge / gate polarity select |
| ext_pin | input | 1 | Asynchronous external input |
| src_en | input | 1 | Fast source clock enable feeding the prescaler |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cnt_rdata | output | 8 | Current counter value |
| ovf_w1c | input | 1 | Write-one strobe that clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that reset is asserted at the start. They also assume that every change on the counter comes from either a bus write or a single increment. They do not model pin timing, so they remain valid for any pin waveform.

The stimulus drives every input on the falling clock edge. Pin changes are never faster than one per clock, so each transition is captured by the synchroniser. In gated runs, the gate level is allowed to settle through the synchroniser before the counter is loaded. Counts are then taken over windows that are whole multiples of the 256-clock prescaler period, so the result does not depend on the prescaler phase.

// File: rtl/pulse_acc_pkg.sv
package pulse_acc_pkg;
    localparam int CNT_W = 8;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } acc_state_t;
endpackage

// File: rtl/pa_insync.sv
module pa_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic lvl,
    output logic edge_hit
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              last_d, last_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin};
        last_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    assign lvl      = chain_q[STAGES-1];
    // pol = 0 selects a rising edge, pol = 1 a falling edge
    assign edge_hit = pol ? (last_q & ~lvl) : (~last_q & lvl);
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = run ? pre_q + 1'b1 : pre_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && (pre_q == PRE_MAX);
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
    import pulse_acc_pkg::*;
#(
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             mode_gated,
    input  logic             pol_sel,
    input  logic             ext_pin,
    input  logic             src_en,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             ovf_w1c,
    input  logic             ovf_ie,
    output logic             ovf_flag,
    output logic             ovf_irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    acc_state_t st_d, st_q;
    logic       pin_lvl, pin_edge, pre_tick, gate_on, inc, wrap;

    pa_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .pol      (pol_sel),
        .lvl      (pin_lvl),
        .edge_hit (pin_edge)
    );

    pa_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (acc_en & src_en),
        .tick  (pre_tick)
    );

    always_comb begin
        gate_on = pin_lvl ^ pol_sel;
        inc     = acc_en & (mode_gated ? (pre_tick & gate_on) : pin_edge);
        wrap    = 1'b0;
        st_d    = st_q;
        if (cnt_we) begin
            st_d.cnt = cnt_wdata;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = (st_q.cnt == CNT_MAX);
        end
        if (ovf_w1c) st_d.ovf = 1'b0;
        if (wrap)    st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_rdata = st_q.cnt;
    assign ovf_flag  = st_q.ovf;
    assign ovf_irq   = st_q.ovf & ovf_ie;
endmodule

// File: rtl/pulse_acc_chk.sv
module pulse_acc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_en,
    input logic       cnt_we,
    input logic [7:0] cnt_wdata,
    input logic [7:0] cnt_rdata,
    input logic       ovf_w1c,
    input logic       ovf_ie,
    input logic       ovf_flag,
    input logic       ovf_irq
);
    // R7
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_rdata == $past(cnt_wdata));

    // R10
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !cnt_we) |=> $stable(cnt_rdata));

    // R10
    no_set_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !$rose(ovf_flag));

    // R8
    ovf_from_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt_rdata) == 8'hFF && cnt_rdata == 8'h00));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_w1c) |=> ovf_flag);

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_rdata == $past(cnt_rdata) || cnt_rdata == $past(cnt_rdata) + 8'd1));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (ovf_flag && ovf_ie));
endmodule

bind pulse_acc pulse_acc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cnt_rdata (cnt_rdata),
    .ovf_w1c   (ovf_w1c),
    .ovf_ie    (ovf_ie),
    .ovf_flag  (ovf_flag),
    .ovf_irq   (ovf_irq)
);

// File: tb/test_pulse_acc.sv
module test_pulse_acc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, mode_gated = 1'b0, pol_sel = 1'b0, ext_pin = 1'b0;
    logic       src_en = 1'b0, cnt_we = 1'b0, ovf_w1c = 1'b0, ovf_ie = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       ovf_flag, ovf_irq;
    int         n_chk = 0, n_bad = 0, cyc = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    pulse_acc i_pulse_acc (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .mode_gated(mode_gated),
        .pol_sel(pol_sel), .ext_pin(ext_pin), .src_en(src_en),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .ovf_w1c(ovf_w1c), .ovf_ie(ovf_ie), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); ext_pin = ~ext_pin;
        repeat (3) @(negedge clk);
        ext_pin = ~ext_pin;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 cnt", cnt_rdata, 0);
        chk("R1 flag", ovf_flag, 0);
        chk("R1 irq", ovf_irq, 0);
    endtask

    task automatic t_rise();
        mode_gated = 0; pol_sel = 0;
        bus_write(8'd0);
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 latency before", cnt_rdata, 0);
        @(negedge clk);
        chk("R2 latency at", cnt_rdata, 1);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 fall ignored", cnt_rdata, 1);
        for (int i = 0; i < 5; i++) pulse();
        chk("R2 five rises", cnt_rdata, 6);
    endtask

    task automatic t_fall();
        pol_sel = 1;
        bus_write(8'd0);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 rise ignored", cnt_rdata, 0);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 fall counted", cnt_rdata, 1);
        for (int i = 0; i < 3; i++) pulse();
        chk("R3 three falls", cnt_rdata, 4);
        pol_sel = 0;
    endtask

    task automatic t_maxrate();
        bus_write(8'd0);
        for (int i = 0; i < 20; i++) begin
            ext_pin = ~ext_pin;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R4 ten fast rises", cnt_rdata, 10);
    endtask

    task automatic t_gated();
        mode_gated = 1; src_en = 1; pol_sel = 0; ext_pin = 1'b1;
        repeat (6) @(negedge clk);
        bus_write(8'd0);
        repeat (1024) @(posedge clk);
        @(negedge clk);
        chk("R5 high gate 4 ticks", cnt_rdata, 4);
        ext_pin = 1'b0;
        repeat (6) @(negedge clk);
        bus_write(8'd0);
        repeat (1024) @(posedge clk);
        @(negedge clk);
        chk("R6 inactive gate", cnt_rdata, 0);
        pol_sel = 1;
        repeat (6) @(negedge clk);
        bus_write(8'd10);
        repeat (512) @(posedge clk);
        @(negedge clk);
        chk("R5 low gate 2 ticks", cnt_rdata, 12);
        pol_sel = 0; mode_gated = 0; src_en = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_priority();
        bus_write(8'd0);
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = 8'h55;
        @(negedge clk);
        cnt_we = 1'b0;
        chk("R7 write beats inc", cnt_rdata, 8'h55);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 held after", cnt_rdata, 8'h55);
    endtask

    task automatic t_overflow();
        ovf_ie = 0;
        bus_write(8'hFE);
        pulse();
        chk("R8 no flag at FF", ovf_flag, 0);
        pulse();
        chk("R8 wrap value", cnt_rdata, 0);
        chk("R8 flag set", ovf_flag, 1);
        chk("R9 irq masked", ovf_irq, 0);
        ovf_ie = 1;
        @(negedge clk);
        chk("R9 irq raised", ovf_irq, 1);
        pulse();
        chk("R8 flag sticky", ovf_flag, 1);
        ovf_w1c = 1; @(negedge clk); ovf_w1c = 0;
        chk("R8 flag cleared", ovf_flag, 0);
        chk("R9 irq dropped", ovf_irq, 0);
        bus_write(8'hFF);
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        ovf_w1c = 1; @(negedge clk); ovf_w1c = 0;
        chk("R8 set beats clear", ovf_flag, 1);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        ovf_w1c = 1; @(negedge clk); ovf_w1c = 0;
        ovf_ie = 0;
    endtask

    task automatic t_disable();
        bus_write(8'd3);
        acc_en = 0;
        for (int i = 0; i < 4; i++) pulse();
        chk("R10 event frozen", cnt_rdata, 3);
        bus_write(8'hFF);
        chk("R10 write while off", cnt_rdata, 8'hFF);
        mode_gated = 1; src_en = 1; ext_pin = 1'b1;
        repeat (600) @(negedge clk);
        chk("R10 gated frozen", cnt_rdata, 8'hFF);
        chk("R10 no flag", ovf_flag, 0);
        mode_gated = 0; src_en = 0; ext_pin = 1'b0; acc_en = 1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        acc_en = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_maxrate();
        t_gated();
        t_priority();
        t_overflow();
        t_disable();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule